// File: doc/BRIEF.md
# Diverge-Branch Dual-Path Fetch Controller

This block sits in a processor front end and chooses, one instruction slot per cycle, the address to fetch next. In its single-path mode it follows the predicted direction of every branch. When it meets a branch that the instruction stream marks as a diverge point and the confidence estimator rates that branch as unreliable, it starts an episode of dynamic predication. It records the merge address carried with the branch and then fetches both outcomes of the branch, giving the slots to the two paths in turn.

Each path stops as soon as its next address would be the merge address. When both paths have stopped, rename is told to place select operations, and fetch goes back to a single path starting at the merge address. A path that runs too long without reaching the merge address ends the episode. Fetch then continues down the direction the predictor originally chose, and rename is told about the abort. A redirect from the back end overrides all of this on the next cycle. Each fetched slot carries a path tag and a predicated flag, so that later stages can guard its results.

The instruction side answers combinationally: for the address on `fetch_pc`, the branch inputs describe the instruction at that address in the same cycle (`br_valid` low means it is not a branch).

Top module: `dpf_ctrl`

## Requirements
- R1: When the instruction on `fetch_pc` in single-path mode is a branch (`br_valid`) with `br_diverge`=1 and `br_low_conf`=1, the next cycle shows `fetch_pred`=1, `fetch_path`=0, `fetch_pc`=`br_taken_pc`, and `ren_start`=1 for that one cycle.
- R2: In single-path mode, a branch that is not diverge-marked, or that has `br_low_conf`=0, is followed in its predicted direction: `br_taken_pc` if `br_pred_taken`=1, else `br_fall_pc`. A non-branch is followed by `fetch_pc`+STEP (STEP=4). `fetch_pred` stays 0.
- R3: During an episode in which neither path has finished, the slots alternate between the paths. The first predicated slot goes to the taken path (tag 0). Within a path, the next address follows the R2 rule.
- R4: A path finishes in the slot whose next address equals the recorded merge address. The merge address itself is never fetched with `fetch_pred`=1. A path whose start address already equals the merge address is finished from the outset.
- R5: In the cycle after the second path finishes, `fetch_pc` equals the merge address, `fetch_pred`=0, and `ren_select`=1 for one cycle.
- R6: Once one path has finished, every predicated slot goes to the other path.
- R7: If a path fetches LIMIT (64) instructions without finishing, the next cycle has `fetch_pred`=0 and `ren_abort`=1. That cycle's `fetch_pc` is the next address of the path the predictor chose at the diverge branch, or the merge address if that path had finished.
- R8: `fetch_path` is 0 for the taken path and 1 for the not-taken path. In single-path mode it is 0 and `fetch_pred` is 0.
- R9: A diverge-marked low-confidence branch fetched during an episode is followed in its predicted direction and produces no `ren_start`.
- R10: When `redirect_valid` is 1, the next cycle has `fetch_pc`=`redirect_pc`, `fetch_pred`=0 and all three rename pulses at 0.
- R11: If a path's LIMIT-th instruction is also the one that finishes it, the episode ends through R5, with no `ren_abort`.
- R12: During and right after reset, `fetch_pc`=RESET_PC (0x100), `fetch_pred`=0, and the rename pulses are 0. Single-path fetch then proceeds from that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redirect_valid | input | 1 | Back-end redirect or flush |
| redirect_pc | input | AW | Address to resume at after a redirect |
| br_valid | input | 1 | Instruction at `fetch_pc` is a branch |
| br_diverge | input | 1 | Branch carries the diverge mark |
| br_low_conf | input | 1 | Confidence estimator reports low confidence |
| br_pred_taken | input | 1 | Predicted direction of the branch |
| br_taken_pc | input | AW | Target if taken |
| br_fall_pc | input | AW | Fall-through address |
| br_merge_pc | input | AW | Merge address marked for the branch |
| fetch_pc | output | AW | Address fetched this cycle |
| fetch_path | output | 1 | Path tag, 0 taken, 1 not-taken |
| fetch_pred | output | 1 | Slot belongs to a predication episode |
| ren_start | output | 1 | First slot of an episode |
| ren_select | output | 1 | Episode merged; rename inserts select operations |
| ren_abort | output | 1 | Episode abandoned |

## Verification
The two functions that can fall in the same cycle are merge detection and the instruction-limit abort: a path's 64th fetch can be the very slot whose next address is the merge point. The bench sets this up with a hammock whose fall-through address equals the merge point, so that the taken path runs alone for exactly 64 instructions before it arrives. Arrival must win. The scoreboard expects the merge address with `ren_select` and no `ren_abort`, and a checker property forbids the two end events from occurring together. A redirect that lands in the middle of an episode is judged the same way, against the slot that follows it.

// File: rtl/dpf_pkg.sv
package dpf_pkg;

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_DUAL   = 1'b1
  } fetch_mode_e;

  localparam logic PATH_TAKEN = 1'b0;
  localparam logic PATH_FALL  = 1'b1;

  // Path index that matches a predicted direction.
  function automatic logic path_of_dir(input logic pred_taken);
    return pred_taken ? PATH_TAKEN : PATH_FALL;
  endfunction

endpackage

// File: rtl/dpf_path_slot.sv
module dpf_path_slot #(
  parameter int AW    = 32,
  parameter int LIMIT = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          load,
  input  logic [AW-1:0] load_pc,
  input  logic [AW-1:0] load_merge,
  input  logic          grant,
  input  logic [AW-1:0] next_pc,
  input  logic [AW-1:0] merge_pc,
  output logic [AW-1:0] pc,
  output logic          done,
  output logic          arrive,
  output logic          at_limit
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic          live;

  assign live     = grant && !done;
  assign arrive   = live && (next_pc == merge_pc);
  assign at_limit = live && !arrive && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc    <= '0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (clear) begin
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (load) begin
      pc    <= load_pc;
      cnt_q <= '0;
      done  <= (load_pc == load_merge);
    end else if (live) begin
      cnt_q <= cnt_q + CW'(1);
      if (arrive) done <= 1'b1;
      else        pc   <= next_pc;
    end
  end
endmodule

// File: rtl/dpf_turn_arb.sv
module dpf_turn_arb #(
  parameter int NP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          active,
  input  logic [NP-1:0] done,
  output logic          sel,
  output logic [NP-1:0] grant
);
  logic turn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      turn_q <= 1'b0;
    else if (start)  turn_q <= 1'b0;
    else if (active) turn_q <= ~turn_q;
  end

  always_comb begin
    if (done[0])      sel = 1'b1;
    else if (done[1]) sel = 1'b0;
    else              sel = turn_q;
  end

  always_comb begin
    grant = '0;
    for (int i = 0; i < NP; i++)
      grant[i] = active && (sel == i[0]);
  end
endmodule

// File: rtl/dpf_ctrl.sv
module dpf_ctrl
  import dpf_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            LIMIT    = 64,
  parameter int            STEP     = 4,
  parameter logic [AW-1:0] RESET_PC = 'h100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redirect_valid,
  input  logic [AW-1:0] redirect_pc,
  input  logic          br_valid,
  input  logic          br_diverge,
  input  logic          br_low_conf,
  input  logic          br_pred_taken,
  input  logic [AW-1:0] br_taken_pc,
  input  logic [AW-1:0] br_fall_pc,
  input  logic [AW-1:0] br_merge_pc,
  output logic [AW-1:0] fetch_pc,
  output logic          fetch_path,
  output logic          fetch_pred,
  output logic          ren_start,
  output logic          ren_select,
  output logic          ren_abort
);
  localparam int NP = 2;

  // Next address of a single stream given the instruction just fetched.
  function automatic logic [AW-1:0] seq_next(
    input logic [AW-1:0] cur,
    input logic          is_br,
    input logic          taken,
    input logic [AW-1:0] tgt,
    input logic [AW-1:0] fall
  );
    if (is_br) return taken ? tgt : fall;
    return cur + AW'(STEP);
  endfunction

  // Episode start qualifier.
  function automatic logic may_start(
    input logic is_br, input logic div, input logic low,
    input logic [AW-1:0] tgt, input logic [AW-1:0] fall, input logic [AW-1:0] mrg
  );
    return is_br && div && low && !((tgt == mrg) && (fall == mrg));
  endfunction

  fetch_mode_e   mode_q;
  logic [AW-1:0] pc_q;
  logic [AW-1:0] merge_q;
  logic          pdir_q;
  logic          start_q, select_q, abort_q;

  logic [AW-1:0] slot_pc [NP];
  logic [AW-1:0] slot_ld [NP];
  logic [NP-1:0] path_done;
  logic [NP-1:0] slot_arrive;
  logic [NP-1:0] slot_limit;
  logic [NP-1:0] grant;
  logic          sel;

  logic          in_pred;
  logic [AW-1:0] cur_pc;
  logic [AW-1:0] nxt;
  logic [AW-1:0] resume_pc;
  logic          start_ev, finish_ev, abort_ev, clear_ev;

  assign in_pred = (mode_q == MODE_DUAL);
  assign cur_pc  = in_pred ? slot_pc[sel] : pc_q;
  assign nxt     = seq_next(cur_pc, br_valid, br_pred_taken, br_taken_pc, br_fall_pc);

  assign start_ev  = !in_pred && !redirect_valid &&
                     may_start(br_valid, br_diverge, br_low_conf,
                               br_taken_pc, br_fall_pc, br_merge_pc);
  assign finish_ev = in_pred && !redirect_valid && (|slot_arrive) && path_done[~sel];
  assign abort_ev  = in_pred && !redirect_valid && (|slot_limit);
  assign clear_ev  = redirect_valid || finish_ev || abort_ev;

  assign slot_ld[PATH_TAKEN] = br_taken_pc;
  assign slot_ld[PATH_FALL]  = br_fall_pc;

  always_comb begin
    if (sel == pdir_q)           resume_pc = nxt;
    else if (path_done[pdir_q])  resume_pc = merge_q;
    else                         resume_pc = slot_pc[pdir_q];
  end

  dpf_turn_arb #(.NP(NP)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_ev),
    .active (in_pred),
    .done   (path_done),
    .sel    (sel),
    .grant  (grant)
  );

  for (genvar g = 0; g < NP; g++) begin : g_slot
    dpf_path_slot #(.AW(AW), .LIMIT(LIMIT)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (clear_ev),
      .load       (start_ev),
      .load_pc    (slot_ld[g]),
      .load_merge (br_merge_pc),
      .grant      (grant[g]),
      .next_pc    (nxt),
      .merge_pc   (merge_q),
      .pc         (slot_pc[g]),
      .done       (path_done[g]),
      .arrive     (slot_arrive[g]),
      .at_limit   (slot_limit[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_SINGLE;
      pc_q     <= RESET_PC;
      merge_q  <= '0;
      pdir_q   <= PATH_TAKEN;
      start_q  <= 1'b0;
      select_q <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      start_q  <= start_ev;
      select_q <= finish_ev;
      abort_q  <= abort_ev;
      if (redirect_valid) begin
        mode_q <= MODE_SINGLE;
        pc_q   <= redirect_pc;
      end else if (start_ev) begin
        mode_q  <= MODE_DUAL;
        merge_q <= br_merge_pc;
        pdir_q  <= path_of_dir(br_pred_taken);
      end else if (finish_ev) begin
        mode_q <= MODE_SINGLE;
        pc_q   <= merge_q;
      end else if (abort_ev) begin
        mode_q <= MODE_SINGLE;
        pc_q   <= resume_pc;
      end else if (!in_pred) begin
        pc_q <= nxt;
      end
    end
  end

  assign fetch_pc   = cur_pc;
  assign fetch_path = in_pred ? sel : PATH_TAKEN;
  assign fetch_pred = in_pred;
  assign ren_start  = start_q;
  assign ren_select = select_q;
  assign ren_abort  = abort_q;
endmodule

// File: rtl/dpf_ctrl_chk.sv
module dpf_ctrl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          redirect_valid,
  input logic [AW-1:0] redirect_pc,
  input logic          br_valid,
  input logic          br_diverge,
  input logic          br_low_conf,
  input logic [AW-1:0] fetch_pc,
  input logic          fetch_path,
  input logic          fetch_pred,
  input logic          ren_start,
  input logic          ren_select,
  input logic          ren_abort,
  input logic [1:0]    path_done,
  input logic          start_ev,
  input logic          finish_ev,
  input logic          abort_ev
);
  a_r1_enter: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (fetch_pred && ren_start && !fetch_path));

  a_r2_plain_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_pred && br_valid && !(br_diverge && br_low_conf) && !redirect_valid) |=> !fetch_pred);

  a_r3_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_pred && path_done == 2'b00 && !abort_ev && !redirect_valid)
      |=> (!fetch_pred || path_done != 2'b00 || fetch_path != $past(fetch_path)));

  a_r6_solo_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_pred && path_done == 2'b01) |-> fetch_path);

  a_r6_solo_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_pred && path_done == 2'b10) |-> !fetch_path);

  a_r5_select: assert property (@(posedge clk) disable iff (!rst_n)
    finish_ev |=> (ren_select && !fetch_pred));

  a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> (ren_abort && !fetch_pred));

  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(finish_ev && abort_ev));

  a_r9_no_nest: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_pred && !redirect_valid && !finish_ev && !abort_ev) |=> !ren_start);

  a_r10_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> (!fetch_pred && fetch_pc == $past(redirect_pc)
                        && !ren_start && !ren_select && !ren_abort));

  a_r8_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ren_start, ren_select, ren_abort}));
endmodule

bind dpf_ctrl dpf_ctrl_chk #(.AW(AW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .br_valid       (br_valid),
  .br_diverge     (br_diverge),
  .br_low_conf    (br_low_conf),
  .fetch_pc       (fetch_pc),
  .fetch_path     (fetch_path),
  .fetch_pred     (fetch_pred),
  .ren_start      (ren_start),
  .ren_select     (ren_select),
  .ren_abort      (ren_abort),
  .path_done      (path_done),
  .start_ev       (start_ev),
  .finish_ev      (finish_ev),
  .abort_ev       (abort_ev)
);

// File: tb/dpf_ctrl_test.sv
module dpf_ctrl_test;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          redirect_valid = 1'b0;
  logic [AW-1:0] redirect_pc = '0;
  logic          br_valid, br_diverge, br_low_conf, br_pred_taken;
  logic [AW-1:0] br_taken_pc, br_fall_pc, br_merge_pc;
  logic [AW-1:0] fetch_pc;
  logic          fetch_path, fetch_pred, ren_start, ren_select, ren_abort;

  always #5 clk = ~clk;

  dpf_ctrl uut (.*);

  // Instruction-side model: up to four branches at fixed addresses.
  logic          t_v  [4];
  logic [AW-1:0] t_a  [4];
  logic          t_dv [4];
  logic          t_lc [4];
  logic          t_pt [4];
  logic [AW-1:0] t_tp [4];
  logic [AW-1:0] t_fp [4];
  logic [AW-1:0] t_mp [4];

  always_comb begin
    br_valid = 1'b0; br_diverge = 1'b0; br_low_conf = 1'b0; br_pred_taken = 1'b0;
    br_taken_pc = '0; br_fall_pc = '0; br_merge_pc = '0;
    for (int i = 0; i < 4; i++) begin
      if (t_v[i] && t_a[i] == fetch_pc) begin
        br_valid = 1'b1; br_diverge = t_dv[i]; br_low_conf = t_lc[i];
        br_pred_taken = t_pt[i]; br_taken_pc = t_tp[i];
        br_fall_pc = t_fp[i]; br_merge_pc = t_mp[i];
      end
    end
  end

  typedef struct {
    logic [AW-1:0] pc;
    logic path, pred, st, sl, ab;
    string req;
  } item_t;

  item_t exp_q[$];
  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  task automatic push(input logic [AW-1:0] pc, input logic path, input logic pred,
                      input logic st, input logic sl, input logic ab, input string req);
    item_t it;
    it.pc = pc; it.path = path; it.pred = pred; it.st = st; it.sl = sl; it.ab = ab; it.req = req;
    exp_q.push_back(it);
  endtask

  // Monitor: compare one expected slot per cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      item_t e;
      e = exp_q.pop_front();
      checks++;
      if (fetch_pc !== e.pc || fetch_path !== e.path || fetch_pred !== e.pred ||
          ren_start !== e.st || ren_select !== e.sl || ren_abort !== e.ab) begin
        failures++;
        $display("FAIL %s actual pc=%h path=%b pred=%b st=%b sel=%b ab=%b expected pc=%h path=%b pred=%b st=%b sel=%b ab=%b",
                 e.req, fetch_pc, fetch_path, fetch_pred, ren_start, ren_select, ren_abort,
                 e.pc, e.path, e.pred, e.st, e.sl, e.ab);
      end
    end
  end

  task automatic clear_tbl();
    for (int i = 0; i < 4; i++) begin
      t_v[i] = 0; t_a[i] = '0; t_dv[i] = 0; t_lc[i] = 0; t_pt[i] = 0;
      t_tp[i] = '0; t_fp[i] = '0; t_mp[i] = '0;
    end
  endtask

  task automatic set_br(input int i, input logic [AW-1:0] a, input logic dv, input logic lc,
                        input logic pt, input logic [AW-1:0] tp, input logic [AW-1:0] fp,
                        input logic [AW-1:0] mp);
    t_v[i] = 1; t_a[i] = a; t_dv[i] = dv; t_lc[i] = lc; t_pt[i] = pt;
    t_tp[i] = tp; t_fp[i] = fp; t_mp[i] = mp;
  endtask

  task automatic go(input logic [AW-1:0] pc);
    @(negedge clk); #1;
    redirect_valid = 1'b1; redirect_pc = pc;
    clear_tbl();
  endtask

  task automatic release_redirect();
    @(negedge clk); #1;
    redirect_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog actual cycles=%0d expected below 20000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    clear_tbl();
    // R12: reset state
    repeat (2) @(negedge clk);
    #1;
    checks++;
    if (fetch_pc !== 32'h100 || fetch_pred !== 1'b0 || ren_start !== 1'b0 ||
        ren_select !== 1'b0 || ren_abort !== 1'b0) begin
      failures++;
      $display("FAIL R12 actual pc=%h pred=%b expected pc=00000100 pred=0", fetch_pc, fetch_pred);
    end
    rst_n = 1'b1;
    push(32'h104, 0, 0, 0, 0, 0, "R12 first step");
    push(32'h108, 0, 0, 0, 0, 0, "R12 second step");
    drain();

    // R2: ordinary branch and high-confidence diverge branch follow prediction
    go(32'h1000);
    set_br(0, 32'h1008, 0, 1, 1, 32'h2000, 32'h100C, 32'h0);
    set_br(1, 32'h2004, 1, 0, 0, 32'h3000, 32'h2008, 32'h2010);
    push(32'h1000, 0, 0, 0, 0, 0, "R10 redirect target");
    push(32'h1004, 0, 0, 0, 0, 0, "R2 sequential");
    push(32'h1008, 0, 0, 0, 0, 0, "R2 sequential");
    push(32'h2000, 0, 0, 0, 0, 0, "R2 predicted taken");
    push(32'h2004, 0, 0, 0, 0, 0, "R2 sequential");
    push(32'h2008, 0, 0, 0, 0, 0, "R2 high confidence diverge not entered");
    release_redirect();
    drain();

    // R1 R3 R4 R5 R8: balanced hammock
    go(32'h3000);
    set_br(0, 32'h3000, 1, 1, 1, 32'h3100, 32'h3004, 32'h3010);
    set_br(1, 32'h3108, 0, 0, 1, 32'h3010, 32'h310C, 32'h0);
    push(32'h3000, 0, 0, 0, 0, 0, "R8 single path tag");
    push(32'h3100, 0, 1, 1, 0, 0, "R1 enter taken path first");
    push(32'h3004, 1, 1, 0, 0, 0, "R3 alternate to fall path");
    push(32'h3104, 0, 1, 0, 0, 0, "R3 alternate");
    push(32'h3008, 1, 1, 0, 0, 0, "R3 alternate");
    push(32'h3108, 0, 1, 0, 0, 0, "R4 taken path last slot");
    push(32'h300C, 1, 1, 0, 0, 0, "R4 fall path last slot");
    push(32'h3010, 0, 0, 0, 1, 0, "R5 merge and select");
    push(32'h3014, 0, 0, 0, 0, 0, "R5 single path continues");
    release_redirect();
    drain();

    // R6 R9: short taken path, nested diverge ignored on the fall path
    go(32'h4000);
    set_br(0, 32'h4000, 1, 1, 0, 32'h4100, 32'h4004, 32'h4020);
    set_br(1, 32'h4100, 0, 0, 1, 32'h4020, 32'h4104, 32'h0);
    set_br(2, 32'h4008, 1, 1, 1, 32'h4010, 32'h400C, 32'h4030);
    push(32'h4000, 0, 0, 0, 0, 0, "R2 before episode");
    push(32'h4100, 0, 1, 1, 0, 0, "R1 enter");
    push(32'h4004, 1, 1, 0, 0, 0, "R6 remaining path");
    push(32'h4008, 1, 1, 0, 0, 0, "R6 remaining path");
    push(32'h4010, 1, 1, 0, 0, 0, "R9 nested diverge followed as predicted");
    push(32'h4014, 1, 1, 0, 0, 0, "R6 remaining path");
    push(32'h4018, 1, 1, 0, 0, 0, "R6 remaining path");
    push(32'h401C, 1, 1, 0, 0, 0, "R6 remaining path");
    push(32'h4020, 0, 0, 0, 1, 0, "R5 merge after solo path");
    push(32'h4024, 0, 0, 0, 0, 0, "R5 single path continues");
    release_redirect();
    drain();

    // R7: limit reached on the taken path, predictor chose not-taken
    go(32'h5000);
    set_br(0, 32'h5000, 1, 1, 0, 32'h6000, 32'h5004, 32'h5F00);
    push(32'h5000, 0, 0, 0, 0, 0, "R2 before episode");
    for (int i = 0; i < 64; i++) begin
      push(32'h6000 + 32'(4 * i), 0, 1, (i == 0), 0, 0, "R3 taken slot");
      if (i < 63) push(32'h5004 + 32'(4 * i), 1, 1, 0, 0, 0, "R3 fall slot");
    end
    push(32'h5100, 0, 0, 0, 0, 1, "R7 abort resumes predicted path");
    push(32'h5104, 0, 0, 0, 0, 0, "R7 single path after abort");
    release_redirect();
    drain();

    // R11 R4: fall path starts at merge; taken path arrives on its 64th fetch
    go(32'h6FF0);
    set_br(0, 32'h6FF0, 1, 1, 1, 32'h7000, 32'h7100, 32'h7100);
    push(32'h6FF0, 0, 0, 0, 0, 0, "R2 before episode");
    for (int i = 0; i < 64; i++)
      push(32'h7000 + 32'(4 * i), 0, 1, (i == 0), 0, 0, "R4 fall path finished at start");
    push(32'h7100, 0, 0, 0, 1, 0, "R11 arrival wins over limit");
    push(32'h7104, 0, 0, 0, 0, 0, "R11 single path continues");
    release_redirect();
    drain();

    // R10: redirect during an episode
    go(32'h3000);
    set_br(0, 32'h3000, 1, 1, 1, 32'h3100, 32'h3004, 32'h3010);
    set_br(1, 32'h3108, 0, 0, 1, 32'h3010, 32'h310C, 32'h0);
    push(32'h3000, 0, 0, 0, 0, 0, "R10 setup");
    push(32'h3100, 0, 1, 1, 0, 0, "R1 enter");
    push(32'h3004, 1, 1, 0, 0, 0, "R3 alternate");
    push(32'h9000, 0, 0, 0, 0, 0, "R10 redirect mid-episode");
    push(32'h9004, 0, 0, 0, 0, 0, "R10 single path after redirect");
    release_redirect();
    @(negedge clk);
    @(negedge clk); #1;
    redirect_valid = 1'b1; redirect_pc = 32'h9000;
    release_redirect();
    drain();

    finished = 1;
    summary();
    $finish;
  end
endmodule